// File: doc/BRIEF.md
# Seconds Counter with Alarm Interrupt

This block keeps time as a free-running seconds count and raises an interrupt when that count reaches a programmed alarm value. It has no clock source of its own. An external strobe, one cycle wide, advances the count by one. Software reaches the block through two register windows that share one write port and one read port. An input selects the window.

The core window holds the count, the alarm value, an interrupt-configuration register and an event-status register. Writes to the core window are posted. The block captures the address and data, raises a busy flag, and applies the write only after a settle delay that a parameter sets in clock cycles. A core write that arrives while the flag is up is dropped, so software must wait for the flag to clear. The wrapper window takes effect at once. It holds a pending/enable register for the outgoing interrupt and a bridge-timing register with two fields. Reads are combinational and always return committed state.

Top module: `rtc_alarm_core`

## Requirements
- R1: After reset every register reads 0, `wr_busy` is 0 and `alarm_irq` is 0.
- R2: Core window (`bus_win`=0) decoding:
  - offset 0x00 returns the status flags in bits 1:0;
  - offset 0x04 returns the configuration in bits 2:0 (bit 0 alarm enable, bit 1 periodic enable, bit 2 one-second rate select);
  - offset 0x0C returns the count;
  - offset 0x10 returns the alarm value;
  - every other offset reads 0.
- R3: A core write accepted at clock edge E takes effect at edge E+SETTLE_CYC. `wr_busy` is 1 after edge E and returns to 0 at the commit edge. Until then, reads return the old value.
- R4: A core write presented while `wr_busy` is 1 is discarded and does not restart the delay.
- R5: Each cycle with `sec_tick` high adds one to the count, including while a write is pending. A committing write to the count in the same cycle as a tick wins over the tick.
- R6: On a tick whose new count equals the alarm value, with configuration bit 0 set, status bit 0 and wrapper pending bit 0 become 1 at that edge. With configuration bit 0 clear, nothing is set.
- R7: A committed status write clears each bit written as 1 and leaves bits written as 0. A same-cycle alarm event wins. Status bit 1 has no source in this block and stays 0.
- R8: Wrapper (`bus_win`=1) offset 0x08 is written at once. Its layout is:
  - bits 1:0 are pending flags, which a write clears where the written bit is 0 and never sets;
  - bits 3:2 are enable bits loaded directly, bit 2 gating the alarm interrupt.
- R9: Wrapper offset 0x00 stores a 10-bit field in bits 9:0 and a 5-bit field in bits 30:26, written at once. All other bits, and other wrapper offsets not named here, read 0.
- R10: `alarm_irq` is 1 exactly when status bit 0, configuration bit 0 and wrapper bit 2 are all 1. Committing 0 to the configuration register drops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle seconds strobe |
| bus_we | input | 1 | Write strobe |
| bus_win | input | 1 | Window select: 0 core, 1 wrapper |
| bus_addr | input | ADDR_W | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_win/bus_addr, combinational |
| wr_busy | output | 1 | Core write pending |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
Results fall due at three different times:
- A core write is checked exactly SETTLE_CYC falling edges after the edge that accepted it. A check one cycle earlier confirms the old value and a raised busy flag.
- Wrapper writes and ticks are checked at the first falling edge after the edge that took them.
- Reads are combinational, so each is sampled 1 ns after its address is driven at a falling edge.

Because of this, every comparison lands in a settled mid-cycle. The same-edge collisions are checked at the commit edge itself: a count load against a tick, and a write arriving while busy.

// File: rtl/rtc_alarm_core.sv
module rtc_alarm_core #(
  parameter int SETTLE_CYC = 250,
  parameter int TIME_W     = 32,
  parameter int ADDR_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              bus_we,
  input  logic              bus_win,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wr_busy,
  output logic              alarm_irq
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_ALRM = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] W_TIM  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] W_INT  = ADDR_W'('h08);

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] p_addr_q;
  logic [31:0]       p_data_q;
  logic [TIME_W-1:0] time_q, alarm_q;
  logic [2:0]        cfg_q;
  logic [1:0]        stat_q, pend_q, mask_q;
  logic [9:0]        period_q;
  logic [4:0]        rdly_q;

  logic core_acc, commit, time_ld, hit, wrap_int_we, wrap_tim_we;

  assign wr_busy     = (cnt_q != '0);
  assign core_acc    = bus_we & ~bus_win & ~wr_busy;
  assign commit      = (cnt_q == CNT_W'(1));
  assign time_ld     = commit & (p_addr_q == A_TIME);
  assign hit         = sec_tick & ~time_ld & cfg_q[0] & ((time_q + TIME_W'(1)) == alarm_q);
  assign wrap_int_we = bus_we & bus_win & (bus_addr == W_INT);
  assign wrap_tim_we = bus_we & bus_win & (bus_addr == W_TIM);
  assign alarm_irq   = stat_q[0] & cfg_q[0] & mask_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      p_addr_q <= '0;
      p_data_q <= '0;
    end else if (core_acc) begin
      cnt_q    <= CNT_W'(SETTLE_CYC);
      p_addr_q <= bus_addr;
      p_data_q <= bus_wdata;
    end else if (wr_busy) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q  <= '0;
      alarm_q <= '0;
      cfg_q   <= '0;
      stat_q  <= '0;
    end else begin
      if (time_ld)                           time_q <= p_data_q[TIME_W-1:0];
      else if (sec_tick)                     time_q <= time_q + TIME_W'(1);
      if (commit && p_addr_q == A_ALRM)      alarm_q <= p_data_q[TIME_W-1:0];
      if (commit && p_addr_q == A_CFG)       cfg_q <= p_data_q[2:0];
      if (commit && p_addr_q == A_STAT)      stat_q <= stat_q & ~p_data_q[1:0];
      if (hit)                               stat_q[0] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      mask_q   <= '0;
      period_q <= '0;
      rdly_q   <= '0;
    end else begin
      if (wrap_int_we) begin
        pend_q <= pend_q & bus_wdata[1:0];
        mask_q <= bus_wdata[3:2];
      end
      if (hit) pend_q[0] <= 1'b1;
      if (wrap_tim_we) begin
        period_q <= bus_wdata[9:0];
        rdly_q   <= bus_wdata[30:26];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (!bus_win) begin
      case (bus_addr)
        A_STAT:  bus_rdata[1:0] = stat_q;
        A_CFG:   bus_rdata[2:0] = cfg_q;
        A_TIME:  bus_rdata = 32'(time_q);
        A_ALRM:  bus_rdata = 32'(alarm_q);
        default: bus_rdata = '0;
      endcase
    end else begin
      case (bus_addr)
        W_TIM: begin
          bus_rdata[9:0]   = period_q;
          bus_rdata[30:26] = rdly_q;
        end
        W_INT:   bus_rdata[3:0] = {mask_q, pend_q};
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/rtc_alarm_core_chk.sv
module rtc_alarm_core_chk #(
  parameter int TIME_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sec_tick,
  input logic              bus_we,
  input logic              bus_win,
  input logic              wr_busy,
  input logic              alarm_irq,
  input logic [TIME_W-1:0] time_q,
  input logic [1:0]        stat_q,
  input logic [1:0]        pend_q
);
  AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_busy) |-> $past(bus_we && !bus_win)); // R3
  AST_TIME_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(time_q) |-> ($past(sec_tick) || $fell(wr_busy))); // R5
  AST_EVENT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[0]) |-> $past(sec_tick)); // R6
  AST_STATUS_CLR_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q[0]) |-> $fell(wr_busy)); // R7
  AST_PEND_CLR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q[0]) |-> $past(bus_we && bus_win)); // R8
  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_irq) |-> ($past(sec_tick) || $fell(wr_busy) || $past(bus_we && bus_win))); // R10
endmodule

bind rtc_alarm_core rtc_alarm_core_chk #(.TIME_W(TIME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_we(bus_we), .bus_win(bus_win),
  .wr_busy(wr_busy), .alarm_irq(alarm_irq), .time_q(time_q), .stat_q(stat_q), .pend_q(pend_q)
);

// File: tb/rtc_alarm_core_tb.sv
module rtc_alarm_core_tb;
  localparam int S = 8;

  logic clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0;
  logic bus_we = 1'b0, bus_win = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic wr_busy, alarm_irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_alarm_core #(.SETTLE_CYC(S), .TIME_W(32), .ADDR_W(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_we(bus_we), .bus_win(bus_win),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wr_busy(wr_busy), .alarm_irq(alarm_irq)
  );

  typedef struct packed {
    logic        win;
    logic [4:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b0, 5'h04, 32'hFFFFFFFF, 32'h00000007},  // R2 cfg keeps 3 bits
    '{1'b0, 5'h04, 32'h00000000, 32'h00000000},  // R2
    '{1'b0, 5'h10, 32'hDEADBEEF, 32'hDEADBEEF},  // R2 alarm
    '{1'b0, 5'h0C, 32'h12345678, 32'h12345678},  // R2 count
    '{1'b0, 5'h08, 32'hFFFFFFFF, 32'h00000000},  // R2 unmapped offset
    '{1'b0, 5'h00, 32'h00000003, 32'h00000000},  // R7 clear when nothing set
    '{1'b1, 5'h00, 32'hFFFFFFFF, 32'h7C0003FF},  // R9 fields only
    '{1'b1, 5'h00, 32'hA5A5A5A5, 32'h240001A5},  // R9
    '{1'b1, 5'h08, 32'h0000000F, 32'h0000000C},  // R8 pending never set by write
    '{1'b1, 5'h08, 32'h00000000, 32'h00000000}   // R8
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rchk(input string tag, input logic w, input logic [4:0] a, input logic [31:0] exp);
    bus_win  = w;
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic wr(input logic w, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_win = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic cwr(input logic [4:0] a, input logic [31:0] d);
    wr(1'b0, a, d);
    repeat (S) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rchk("R1 status", 1'b0, 5'h00, 32'h0);
    rchk("R1 cfg", 1'b0, 5'h04, 32'h0);
    rchk("R1 count", 1'b0, 5'h0C, 32'h0);
    rchk("R1 alarm", 1'b0, 5'h10, 32'h0);
    rchk("R1 timing", 1'b1, 5'h00, 32'h0);
    rchk("R1 int", 1'b1, 5'h08, 32'h0);
    chk("R1 busy", {31'b0, wr_busy}, 32'h0);
    chk("R1 irq", {31'b0, alarm_irq}, 32'h0);

    for (int i = 0; i < 10; i++) begin
      wr(VECS[i].win, VECS[i].addr, VECS[i].wdata);
      repeat (S) @(negedge clk);
      rchk($sformatf("R2/R7/R8/R9 vector %0d", i), VECS[i].win, VECS[i].addr, VECS[i].exp);
    end

    // R3 posted commit timing
    wr(1'b0, 5'h10, 32'h55);
    repeat (S - 1) @(negedge clk);
    rchk("R3 old value before commit", 1'b0, 5'h10, 32'hDEADBEEF);
    chk("R3 busy before commit", {31'b0, wr_busy}, 32'h1);
    @(negedge clk);
    rchk("R3 new value at commit", 1'b0, 5'h10, 32'h55);
    chk("R3 busy after commit", {31'b0, wr_busy}, 32'h0);

    // R4 write while busy dropped
    wr(1'b0, 5'h0C, 32'd100);
    wr(1'b0, 5'h0C, 32'd200);
    repeat (S - 2) @(negedge clk);
    rchk("R4 first write committed", 1'b0, 5'h0C, 32'd100);
    chk("R4 busy not rearmed", {31'b0, wr_busy}, 32'h0);
    repeat (S) @(negedge clk);
    rchk("R4 second write dropped", 1'b0, 5'h0C, 32'd100);

    // R5 ticks
    tick();
    rchk("R5 tick increments", 1'b0, 5'h0C, 32'd101);
    wr(1'b0, 5'h0C, 32'd300);
    tick();
    rchk("R5 count runs while pending", 1'b0, 5'h0C, 32'd102);
    repeat (S - 2) @(negedge clk);
    rchk("R5 load after pending", 1'b0, 5'h0C, 32'd300);
    wr(1'b0, 5'h0C, 32'd400);
    repeat (S - 1) @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    rchk("R5 load wins over tick", 1'b0, 5'h0C, 32'd400);

    // R6 alarm event and R10 interrupt
    cwr(5'h10, 32'd405);
    cwr(5'h04, 32'h1);
    wr(1'b1, 5'h08, 32'h4);
    repeat (4) tick();
    rchk("R6 no event before match", 1'b0, 5'h00, 32'h0);
    chk("R10 irq low before match", {31'b0, alarm_irq}, 32'h0);
    tick();
    rchk("R6 status set on match", 1'b0, 5'h00, 32'h1);
    rchk("R6 wrapper pending set", 1'b1, 5'h08, 32'h5);
    chk("R10 irq high", {31'b0, alarm_irq}, 32'h1);

    wr(1'b1, 5'h08, 32'h0);
    chk("R10 irq masked", {31'b0, alarm_irq}, 32'h0);
    rchk("R8 pending cleared by zero", 1'b1, 5'h08, 32'h0);
    rchk("R7 status kept", 1'b0, 5'h00, 32'h1);
    wr(1'b1, 5'h08, 32'h5);
    rchk("R8 pending not set by one", 1'b1, 5'h08, 32'h4);
    chk("R10 irq unmasked", {31'b0, alarm_irq}, 32'h1);

    cwr(5'h04, 32'h0);
    chk("R10 cfg zero drops irq", {31'b0, alarm_irq}, 32'h0);
    cwr(5'h04, 32'h1);
    chk("R10 cfg restored", {31'b0, alarm_irq}, 32'h1);

    cwr(5'h00, 32'h2);
    rchk("R7 zero bit leaves flag", 1'b0, 5'h00, 32'h1);
    cwr(5'h00, 32'h1);
    rchk("R7 one clears flag", 1'b0, 5'h00, 32'h0);
    chk("R10 irq after ack", {31'b0, alarm_irq}, 32'h0);

    cwr(5'h04, 32'h0);
    cwr(5'h0C, 32'd500);
    cwr(5'h10, 32'd501);
    tick();
    rchk("R6 disabled count", 1'b0, 5'h0C, 32'd501);
    rchk("R6 disabled no event", 1'b0, 5'h00, 32'h0);
    rchk("R6 disabled no pending", 1'b1, 5'h08, 32'h4);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL all requirements: watchdog got running expected finished");
      summary();
      $finish;
    end
  end
endmodule